// File: doc/BRIEF.md
# CPU-to-Wishbone Bus Gateway

This block sits between a simple single-beat CPU memory request port and an external Wishbone B4 master interface. A request whose address falls in no enabled internal region (instruction memory window, data memory window, or the boot ROM and IO area at the top of the map) is forwarded as one Wishbone cycle. A request that an internal region claims is left alone. Read data and a one-cycle completion pulse return to the CPU, along with a fault flag for bus errors and timeouts.

Parameters set the strobe style (classic or pipelined), an optional watchdog that cancels an unanswered cycle, the external byte order, and whether the response path is registered or direct. A 3-bit tag gives the privilege level and the access kind. A lock output, raised by a load-reserved request, asks the interconnect to hold a reservation.

Top module: `extbus_gate`

## Requirements
- R1: A request whose address lies in `[IMEM_BASE, IMEM_BASE+IMEM_SIZE)` (when IMEM_ON), in `[DMEM_BASE, DMEM_BASE+DMEM_SIZE)` (when DMEM_ON), or at or above ROM_BASE (default 0xFFFF0000) starts no bus cycle. Any other request, made while idle, raises `bus_cyc` together with its address, data, byte enables and write enable in the next cycle.
- R2: In classic mode `bus_stb` equals `bus_cyc`. All bus outputs stay stable until acknowledge, error or timeout.
- R3: In pipelined mode `bus_stb` is high only in the first cycle of a transfer, while `bus_cyc` and the other outputs stay stable until it ends.
- R4: With TIMEOUT=N>0, a cycle that gets neither acknowledge nor error keeps `bus_cyc` high for exactly N cycles, then drops it and reports a fault. With TIMEOUT=0 a cycle waits without limit.
- R5: With the registered response path, `rsp_done` pulses in the cycle after the acknowledge is sampled, which is the same cycle in which `bus_cyc` is low again. With DIRECT_RX, `rsp_done` and `rsp_rdata` follow the acknowledge in the same cycle.
- R6: An error, or acknowledge and error together, ends the cycle with `rsp_fault` high for exactly one cycle and `rsp_rdata` forced to zero.
- R7: `bus_tag[0]` is the privileged flag, `bus_tag[1]` is always 0, and `bus_tag[2]` is 1 for an instruction fetch.
- R8: A forwarded request with `req_lr` set raises `bus_lock` with its cycle. Lock stays high after completion until the next forwarded request without `req_lr`, which clears it when that request's cycle starts.
- R9: With BIG_ENDIAN, external byte lane i carries internal byte NB-1-i, for write data, byte enables and read data alike. Without BIG_ENDIAN the lanes map straight through.
- R10: A request presented while a cycle is in progress is ignored. It does not change the bus outputs and is not issued later.
- R11: After reset `bus_cyc`, `bus_stb`, `bus_lock`, `rsp_done` and `rsp_fault` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low reset |
| req_valid | input | 1 | CPU request strobe |
| req_addr | input | AW | request address |
| req_wdata | input | DW | write data, little-endian |
| req_be | input | DW/8 | byte enables |
| req_write | input | 1 | 1 = write |
| req_priv | input | 1 | machine-mode access |
| req_fetch | input | 1 | instruction fetch |
| req_lr | input | 1 | load-reserved |
| rsp_done | output | 1 | access finished pulse |
| rsp_fault | output | 1 | access ended by error or timeout |
| rsp_rdata | output | DW | read data |
| bus_adr | output | AW | Wishbone address |
| bus_dato | output | DW | Wishbone write data |
| bus_sel | output | DW/8 | Wishbone byte select |
| bus_we | output | 1 | Wishbone write enable |
| bus_stb | output | 1 | Wishbone strobe |
| bus_cyc | output | 1 | Wishbone cycle |
| bus_lock | output | 1 | exclusive access request |
| bus_tag | output | 3 | access tag |
| bus_dati | input | DW | Wishbone read data |
| bus_ack | input | 1 | Wishbone acknowledge |
| bus_err | input | 1 | Wishbone error |

## Verification
Two instances are driven side by side. One is classic, registered, little-endian, with an 8-cycle timeout. The other is pipelined, direct, big-endian, with no timeout. This contrast separates strobe shape, response latency and lane order. The slave replies with zero-wait acknowledges, with delayed acknowledges, with errors, with acknowledge and error together, and with silence. The delayed replies check output stability and the silent ones check the timeout. Addresses inside each internal window and just outside them test the forwarding decision. Load-reserved requests followed by plain ones, and requests issued mid-cycle, exercise the lock and the busy drop.

// File: rtl/extbus_gate.sv
module extbus_gate #(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter bit PIPELINED = 1'b0,
  parameter bit BIG_ENDIAN = 1'b0,
  parameter bit DIRECT_RX = 1'b0,
  parameter int TIMEOUT = 0,
  parameter bit IMEM_ON = 1'b1,
  parameter logic [AW-1:0] IMEM_BASE = AW'(32'h0000_0000),
  parameter logic [AW-1:0] IMEM_SIZE = AW'(32'h0000_8000),
  parameter bit DMEM_ON = 1'b1,
  parameter logic [AW-1:0] DMEM_BASE = AW'(32'h8000_0000),
  parameter logic [AW-1:0] DMEM_SIZE = AW'(32'h0000_2000),
  parameter logic [AW-1:0] ROM_BASE = AW'(32'hFFFF_0000)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic [DW/8-1:0] req_be,
  input  logic          req_write,
  input  logic          req_priv,
  input  logic          req_fetch,
  input  logic          req_lr,
  output logic          rsp_done,
  output logic          rsp_fault,
  output logic [DW-1:0] rsp_rdata,
  output logic [AW-1:0] bus_adr,
  output logic [DW-1:0] bus_dato,
  output logic [DW/8-1:0] bus_sel,
  output logic          bus_we,
  output logic          bus_stb,
  output logic          bus_cyc,
  output logic          bus_lock,
  output logic [2:0]    bus_tag,
  input  logic [DW-1:0] bus_dati,
  input  logic          bus_ack,
  input  logic          bus_err
);
  localparam int NB = DW / 8;
  localparam int CW = (TIMEOUT > 1) ? $clog2(TIMEOUT + 1) : 1;

  logic [DW-1:0] wd_x, rd_x;
  logic [NB-1:0] sel_x;
  logic claimed, start, expire, fin, bad;

  assign claimed = (IMEM_ON && ((req_addr - IMEM_BASE) < IMEM_SIZE)) ||
                   (DMEM_ON && ((req_addr - DMEM_BASE) < DMEM_SIZE)) ||
                   (req_addr >= ROM_BASE);
  assign start = req_valid && !bus_cyc && !claimed;

  genvar b;
  generate
    for (b = 0; b < NB; b++) begin : g_lane
      if (BIG_ENDIAN) begin : g_be
        assign wd_x[8*b +: 8] = req_wdata[8*(NB-1-b) +: 8];
        assign rd_x[8*b +: 8] = bus_dati[8*(NB-1-b) +: 8];
        assign sel_x[b]       = req_be[NB-1-b];
      end else begin : g_le
        assign wd_x[8*b +: 8] = req_wdata[8*b +: 8];
        assign rd_x[8*b +: 8] = bus_dati[8*b +: 8];
        assign sel_x[b]       = req_be[b];
      end
    end
  endgenerate

  generate
    if (TIMEOUT > 0) begin : g_tmo
      logic [CW-1:0] cnt;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       cnt <= '0;
        else if (start)   cnt <= CW'(TIMEOUT);
        else if (bus_cyc) cnt <= cnt - 1'b1;
        else              cnt <= '0;
      end
      assign expire = bus_cyc && (cnt == CW'(1)) && !bus_ack && !bus_err;
    end else begin : g_notmo
      assign expire = 1'b0;
    end
  endgenerate

  assign fin = bus_cyc && (bus_ack || bus_err || expire);
  assign bad = bus_cyc && (bus_err || expire);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_cyc  <= 1'b0;
      bus_stb  <= 1'b0;
      bus_lock <= 1'b0;
      bus_we   <= 1'b0;
      bus_adr  <= '0;
      bus_dato <= '0;
      bus_sel  <= '0;
      bus_tag  <= '0;
    end else if (start) begin
      bus_cyc  <= 1'b1;
      bus_stb  <= 1'b1;
      bus_lock <= req_lr;
      bus_we   <= req_write;
      bus_adr  <= req_addr;
      bus_dato <= wd_x;
      bus_sel  <= sel_x;
      bus_tag  <= {req_fetch, 1'b0, req_priv};
    end else if (fin) begin
      bus_cyc <= 1'b0;
      bus_stb <= 1'b0;
    end else if (PIPELINED) begin
      bus_stb <= 1'b0;
    end
  end

  generate
    if (DIRECT_RX) begin : g_rx_direct
      assign rsp_done  = fin;
      assign rsp_fault = bad;
      assign rsp_rdata = bad ? '0 : rd_x;
    end else begin : g_rx_reg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          rsp_done  <= 1'b0;
          rsp_fault <= 1'b0;
          rsp_rdata <= '0;
        end else begin
          rsp_done  <= fin;
          rsp_fault <= bad;
          rsp_rdata <= bad ? '0 : rd_x;
        end
      end
    end
  endgenerate

  logic [31:0] age;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       age <= '0;
    else if (bus_cyc) age <= age + 1'b1;
    else              age <= '0;
  end

  assert_fwd_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_cyc) |-> $past(req_valid));

  // R2 and R3: outputs held while the slave has not answered
  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_cyc && !bus_ack && !bus_err && !expire) |=>
      (bus_cyc && $stable(bus_adr) && $stable(bus_sel) && $stable(bus_we) &&
       $stable(bus_dato) && $stable(bus_tag) && $stable(bus_lock)));

  generate
    if (PIPELINED) begin : g_chk_pipe
      assert_stb_once_R3: assert property (@(posedge clk) disable iff (!rst_n)
        bus_stb |=> !bus_stb);
    end else begin : g_chk_classic
      assert_stb_cyc_R2: assert property (@(posedge clk) disable iff (!rst_n)
        bus_cyc |-> bus_stb);
    end
    if (TIMEOUT > 0) begin : g_chk_tmo
      assert_window_R4: assert property (@(posedge clk) disable iff (!rst_n)
        bus_cyc |-> (age < 32'(TIMEOUT)));
    end
  endgenerate

  assert_fault_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_fault |-> (rsp_done && rsp_rdata == '0));

  assert_fault_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_fault |=> !rsp_fault);

  assert_lock_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_lock) |-> $rose(bus_cyc));

endmodule

// File: tb/sim_extbus_gate.sv
`timescale 1ns/1ps
module sim_extbus_gate;
  logic clk = 1'b0, rst_n = 1'b0;
  always #4 clk = ~clk;

  int total = 0, fails = 0;

  // u0: classic, registered rx, little-endian, timeout 8
  logic a_valid = 0, a_we = 0, a_priv = 0, a_fetch = 0, a_lr = 0;
  logic [31:0] a_addr = 0, a_wdata = 0, a_dati = 0;
  logic [3:0] a_be = 0;
  logic a_ack = 0, a_err = 0;
  logic a_done, a_fault, a_bwe, a_stb, a_cyc, a_lock;
  logic [31:0] a_rdata, a_adr, a_dato;
  logic [3:0] a_sel;
  logic [2:0] a_tag;

  // u1: pipelined, direct rx, big-endian, no timeout
  logic b_valid = 0, b_we = 0, b_priv = 0, b_fetch = 0, b_lr = 0;
  logic [31:0] b_addr = 0, b_wdata = 0, b_dati = 0;
  logic [3:0] b_be = 0;
  logic b_ack = 0, b_err = 0;
  logic b_done, b_fault, b_bwe, b_stb, b_cyc, b_lock;
  logic [31:0] b_rdata, b_adr, b_dato;
  logic [3:0] b_sel;
  logic [2:0] b_tag;

  extbus_gate #(.TIMEOUT(8)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(a_valid), .req_addr(a_addr),
    .req_wdata(a_wdata), .req_be(a_be), .req_write(a_we), .req_priv(a_priv),
    .req_fetch(a_fetch), .req_lr(a_lr), .rsp_done(a_done), .rsp_fault(a_fault),
    .rsp_rdata(a_rdata), .bus_adr(a_adr), .bus_dato(a_dato), .bus_sel(a_sel),
    .bus_we(a_bwe), .bus_stb(a_stb), .bus_cyc(a_cyc), .bus_lock(a_lock),
    .bus_tag(a_tag), .bus_dati(a_dati), .bus_ack(a_ack), .bus_err(a_err));

  extbus_gate #(.PIPELINED(1'b1), .BIG_ENDIAN(1'b1), .DIRECT_RX(1'b1), .TIMEOUT(0)) u1 (
    .clk(clk), .rst_n(rst_n), .req_valid(b_valid), .req_addr(b_addr),
    .req_wdata(b_wdata), .req_be(b_be), .req_write(b_we), .req_priv(b_priv),
    .req_fetch(b_fetch), .req_lr(b_lr), .rsp_done(b_done), .rsp_fault(b_fault),
    .rsp_rdata(b_rdata), .bus_adr(b_adr), .bus_dato(b_dato), .bus_sel(b_sel),
    .bus_we(b_bwe), .bus_stb(b_stb), .bus_cyc(b_cyc), .bus_lock(b_lock),
    .bus_tag(b_tag), .bus_dati(b_dati), .bus_ack(b_ack), .bus_err(b_err));

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic req_a(input logic [31:0] addr, input logic [31:0] wd, input logic [3:0] be,
                       input logic we, input logic priv, input logic fetch, input logic lr);
    a_valid = 1; a_addr = addr; a_wdata = wd; a_be = be; a_we = we;
    a_priv = priv; a_fetch = fetch; a_lr = lr;
    step();
    a_valid = 0;
  endtask

  task automatic t_reset();
    chk(!a_cyc && !a_stb && !a_lock && !a_done && !a_fault, "R11 u0", {27'd0, a_cyc, a_stb, a_lock, a_done, a_fault}, 0);
    chk(!b_cyc && !b_stb && !b_lock && !b_done && !b_fault, "R11 u1", {27'd0, b_cyc, b_stb, b_lock, b_done, b_fault}, 0);
  endtask

  task automatic t_claimed();
    req_a(32'h0000_0100, 0, 4'hF, 0, 0, 0, 0);
    chk(!a_cyc, "R1 imem claimed", a_cyc, 0);
    req_a(32'h8000_0010, 0, 4'hF, 0, 0, 0, 0);
    chk(!a_cyc, "R1 dmem claimed", a_cyc, 0);
    req_a(32'hFFFF_0004, 0, 4'hF, 0, 0, 0, 0);
    chk(!a_cyc, "R1 rom claimed", a_cyc, 0);
    step();
    chk(!a_done, "R1 no response", a_done, 0);
  endtask

  task automatic t_classic_read();
    req_a(32'h0000_8000, 0, 4'hF, 0, 1, 1, 0);
    chk(a_cyc && a_stb && a_adr == 32'h0000_8000 && !a_bwe, "R1 forward just past imem", a_adr, 32'h0000_8000);
    chk(a_tag == 3'b101, "R7 tag priv fetch", a_tag, 3'b101);
    step(); step();
    chk(a_cyc && a_stb && a_adr == 32'h0000_8000 && a_sel == 4'hF, "R2 held while waiting", {a_cyc, a_stb, 30'd0}, 32'hC000_0000);
    a_ack = 1; a_dati = 32'hCAFE_0123;
    #1;
    chk(!a_done, "R5 registered rx no same-cycle done", a_done, 0);
    step();
    a_ack = 0;
    chk(!a_cyc && a_done && !a_fault && a_rdata == 32'hCAFE_0123, "R5 registered read", a_rdata, 32'hCAFE_0123);
    step();
    chk(!a_done, "R5 done is a pulse", a_done, 0);
  endtask

  task automatic t_classic_write_le();
    req_a(32'h1234_5678, 32'h1122_3344, 4'b0011, 1, 0, 0, 0);
    chk(a_dato == 32'h1122_3344 && a_sel == 4'b0011 && a_bwe, "R9 little-endian lanes", a_dato, 32'h1122_3344);
    chk(a_tag == 3'b000, "R7 tag user data", a_tag, 0);
    a_ack = 1; step(); a_ack = 0;
    chk(a_done && !a_cyc, "R5 write done", a_done, 1);
    step();
  endtask

  task automatic t_error();
    req_a(32'h2000_0000, 0, 4'hF, 0, 0, 0, 0);
    a_err = 1; a_ack = 1; a_dati = 32'hFFFF_FFFF;
    step();
    a_err = 0; a_ack = 0;
    chk(a_done && a_fault && a_rdata == 0, "R6 ack+err gives fault", a_rdata, 0);
    step();
    chk(!a_fault, "R6 fault one cycle", a_fault, 0);
  endtask

  task automatic t_timeout();
    req_a(32'h3000_0000, 0, 4'hF, 0, 0, 0, 0);
    a_dati = 32'h5555_5555;
    for (int i = 0; i < 7; i++) step();
    chk(a_cyc && !a_fault, "R4 cyc high at cycle 8", a_cyc, 1);
    step();
    chk(!a_cyc && a_fault && a_done && a_rdata == 0, "R4 cancelled after 8", {31'd0, a_cyc}, 0);
    step();
    chk(!a_fault, "R4 fault pulse", a_fault, 0);
  endtask

  task automatic t_busy_drop();
    req_a(32'h4000_0000, 32'hAAAA_0000, 4'hF, 1, 0, 0, 0);
    a_valid = 1; a_addr = 32'h4444_0000; a_we = 0;
    step();
    a_valid = 0;
    chk(a_adr == 32'h4000_0000 && a_bwe, "R10 busy request ignored", a_adr, 32'h4000_0000);
    a_ack = 1; step(); a_ack = 0;
    step();
    chk(!a_cyc, "R10 no deferred issue", a_cyc, 0);
  endtask

  task automatic t_lock();
    req_a(32'h5000_0000, 0, 4'hF, 0, 0, 0, 1);
    chk(a_lock && a_cyc, "R8 lock raised", a_lock, 1);
    a_ack = 1; step(); a_ack = 0;
    step(); step();
    chk(a_lock && !a_cyc, "R8 lock kept after completion", a_lock, 1);
    req_a(32'h5000_0000, 32'h1, 4'hF, 1, 0, 0, 0);
    chk(!a_lock && a_cyc, "R8 lock cleared by next access", a_lock, 0);
    a_err = 1; step(); a_err = 0;
    chk(a_fault, "R8 broken reservation faults", a_fault, 1);
    step();
  endtask

  task automatic t_pipe_be();
    b_valid = 1; b_addr = 32'h6000_0000; b_wdata = 32'h1122_3344; b_be = 4'b0011; b_we = 1;
    step(); b_valid = 0;
    chk(b_cyc && b_stb, "R3 stb first cycle", b_stb, 1);
    chk(b_dato == 32'h4433_2211 && b_sel == 4'b1100, "R9 big-endian write lanes", b_dato, 32'h4433_2211);
    step();
    chk(b_cyc && !b_stb && b_adr == 32'h6000_0000, "R3 stb dropped cyc held", {b_cyc, b_stb, 30'd0}, 32'h8000_0000);
    b_ack = 1; #1;
    chk(b_done, "R5 direct rx same cycle", b_done, 1);
    step(); b_ack = 0;
    chk(!b_cyc, "R3 cycle ended", b_cyc, 0);
  endtask

  task automatic t_pipe_read_notmo();
    b_valid = 1; b_addr = 32'h7000_0000; b_we = 0; b_be = 4'hF;
    step(); b_valid = 0;
    for (int i = 0; i < 50; i++) step();
    chk(b_cyc && !b_fault, "R4 no timeout when zero", b_cyc, 1);
    b_dati = 32'hAABB_CCDD; b_ack = 1; #1;
    chk(b_done && b_rdata == 32'hDDCC_BBAA, "R9 big-endian read lanes", b_rdata, 32'hDDCC_BBAA);
    step(); b_ack = 0;
    b_valid = 1; b_addr = 32'h7000_0004;
    step(); b_valid = 0;
    b_err = 1; b_dati = 32'h1234_5678; #1;
    chk(b_fault && b_rdata == 0, "R6 direct error zero data", b_rdata, 0);
    step(); b_err = 0;
    chk(!b_fault, "R6 direct fault one cycle", b_fault, 0);
  endtask

  initial begin
    #(8 * 100000);
    fails++; total++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    #1;
    t_reset();
    step(); step();
    rst_n = 1;
    step();
    t_claimed();
    t_classic_read();
    t_classic_write_le();
    t_error();
    t_timeout();
    t_busy_drop();
    t_lock();
    t_pipe_be();
    t_pipe_read_notmo();
    step();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule